// File: doc/BRIEF.md
# Multi-slot register move unit

This block executes one register-move control instruction at a time. A 64-byte instruction arrives as a 512-bit word on a valid/ready input, together with the 64-bit address of that instruction. The unit first decides whether the instruction is legal. An illegal instruction produces a one-cycle `illegal` pulse and changes nothing. A legal one performs one to eight 32-bit word moves into a 64-entry register file, one slot per clock in ascending slot order, and then produces a one-cycle `done` pulse.

Each moved word comes either from another register or from an immediate word carried in the instruction. Two read-only source specifiers return the low and high halves of the instruction address. The accepted type codes do not change the data path: every word is copied bit for bit. A combinational read port lets the surrounding logic observe any register.

Byte b of the instruction occupies bits `[8b+7:8b]` of `instData`. Multi-byte fields are little-endian.

Top module: `regMoveUnit`

## Requirements
- R1: Byte 0 is the opcode. Any value other than 0xA7 makes the instruction illegal.
- R2: Byte 12 is the move count n. It must lie between 1 and 8. A count of 0 or above 8 is illegal.
- R3: Byte 13 is the type code. Only 0x8, 0x9 and 0xA are legal. All three copy the full 32-bit word unchanged, with no sign extension or conversion.
- R4: Byte 15 is reserved. A nonzero value is illegal.
- R5: Byte 14 selects the source. With 0, slot k copies register src[k] (byte 16+k) into dst[k] (byte 24+k). With 1, slot k copies immediate word k (bytes 32+4k to 35+4k, little-endian) into dst[k]. Any other value is illegal.
- R6: In each active slot (k < n), the source and destination specifiers must each be 0–63, 128 or 129. Any other specifier value is illegal.
- R7: In each inactive slot (k ≥ n), the source specifier must be 0. The destination specifier of an inactive slot is not checked.
- R8: The destinations of the active slots must all differ. No active destination may equal any active source specifier. This rule applies in both source modes.
- R9: An illegal instruction raises `illegal` for exactly one cycle, in the second cycle after acceptance. It leaves every register unchanged.
- R10: Source specifier 128 reads bits 31:0 of the instruction address and 129 reads bits 63:32. A write whose destination is 128 or 129 is dropped.
- R11: A legal instruction with n moves writes one slot per clock. `done` is high for one cycle, n+2 cycles after acceptance. `instReady` is low from the cycle after acceptance until `done`.
- R12: After reset all registers read zero, `instReady` is high, and `done` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word is valid |
| instReady | output | 1 | Unit can accept an instruction |
| instData | input | 512 | The 64-byte instruction, byte 0 in bits 7:0 |
| instAddr | input | 64 | Address of the instruction, captured on acceptance |
| done | output | 1 | One-cycle pulse after the last move |
| illegal | output | 1 | One-cycle pulse for a rejected instruction |
| rdAddr | input | 6 | Register read port address |
| rdData | output | 32 | Contents of the addressed register |

## Verification
The assertions assume that the environment drops `instValid` or changes `instData` only after an acceptance has occurred. They also assume that reset is held for at least one clock edge before the first instruction. The bench presents each instruction for exactly one accepting edge and waits for `done` or `illegal` before presenting the next one. It drives the read port only while the unit is idle. Randomly generated legal instructions always use distinct destinations and take their register sources from outside the destination set, so they stay legal by construction. The illegal cases break exactly one rule each.

// File: rtl/rmv_pkg.sv
package rmv_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int WORD_W    = 32;
  localparam int NUM_REGS  = 64;
  localparam int REG_AW    = $clog2(NUM_REGS);
  localparam int INST_W    = 512;
  localparam int ADDR_W    = 64;
  localparam int SPEC_W    = 8;

  localparam int CNT_LSB  = 96;
  localparam int TYPE_LSB = 104;
  localparam int MODE_LSB = 112;
  localparam int RSV_LSB  = 120;
  localparam int SRC_LSB  = 128;
  localparam int DST_LSB  = SRC_LSB + NUM_SLOTS * SPEC_W;
  localparam int IMM_LSB  = 256;

  localparam logic [7:0] OPC_MOVE  = 8'hA7;
  localparam logic [7:0] SPEC_PCLO = 8'd128;
  localparam logic [7:0] SPEC_PCHI = 8'd129;
  localparam logic [7:0] MODE_REG  = 8'd0;
  localparam logic [7:0] MODE_IMM  = 8'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_MOVE} seqState_t;

  typedef struct packed {
    logic              load;
    logic              wrEn;
    logic [SLOT_W-1:0] slot;
  } ctlStrb_t;
endpackage

// File: rtl/rmv_legal.sv
module rmv_legal
  import rmv_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS,
  parameter int REGS  = NUM_REGS
) (
  input  logic [INST_W-1:0]  inst,
  output logic               legal,
  output logic [SLOT_W:0]    moveCount
);
  logic [7:0] opcode, cnt, typeCode, mode, rsvd;
  logic [SLOTS-1:0] slotOk;
  logic [SLOTS-1:0] aliasHit;
  logic unusedHeader;

  assign opcode    = inst[7:0];
  assign cnt       = inst[CNT_LSB +: 8];
  assign typeCode  = inst[TYPE_LSB +: 8];
  assign mode      = inst[MODE_LSB +: 8];
  assign rsvd      = inst[RSV_LSB +: 8];
  assign moveCount = cnt[SLOT_W:0];
  assign unusedHeader = ^inst[CNT_LSB-1:8] ^ ^inst[INST_W-1:IMM_LSB];

  function automatic logic specOk(input logic [7:0] s);
    return (s < 8'(REGS)) || (s == SPEC_PCLO) || (s == SPEC_PCHI);
  endfunction

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [7:0] srcK, dstK;
    logic       activeK;
    logic [SLOTS-1:0] hitK;
    assign srcK    = inst[SRC_LSB + SPEC_W*k +: SPEC_W];
    assign dstK    = inst[DST_LSB + SPEC_W*k +: SPEC_W];
    assign activeK = cnt > 8'(k);
    assign slotOk[k] = activeK ? (specOk(srcK) && specOk(dstK)) : (srcK == 8'd0);
    for (genvar j = 0; j < SLOTS; j++) begin : g_pair
      logic [7:0] srcJ, dstJ;
      logic       activeJ;
      assign srcJ    = inst[SRC_LSB + SPEC_W*j +: SPEC_W];
      assign dstJ    = inst[DST_LSB + SPEC_W*j +: SPEC_W];
      assign activeJ = cnt > 8'(j);
      if (j == k) begin : g_self
        assign hitK[j] = activeK && (dstK == srcJ);
      end else begin : g_other
        assign hitK[j] = activeK && activeJ && ((dstK == dstJ) || (dstK == srcJ));
      end
    end
    assign aliasHit[k] = |hitK;
  end

  always_comb begin
    legal = (opcode == OPC_MOVE)
         && (cnt != 8'd0) && (cnt <= 8'(SLOTS))
         && (typeCode == 8'h8 || typeCode == 8'h9 || typeCode == 8'hA)
         && (rsvd == 8'd0)
         && (mode == MODE_REG || mode == MODE_IMM)
         && (&slotOk)
         && !(|aliasHit);
  end
endmodule

// File: rtl/rmv_ctrl.sv
module rmv_ctrl
  import rmv_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic            legal,
  input  logic [SLOT_W:0] moveCount,
  output logic            instReady,
  output ctlStrb_t        strobes,
  output logic            done,
  output logic            illegal
);
  seqState_t         state;
  logic [SLOT_W-1:0] slotIdx;
  logic              lastSlot;

  assign lastSlot = ({1'b0, slotIdx} == (moveCount - 1'b1));

  always_comb begin
    instReady     = (state == ST_IDLE);
    strobes.load  = (state == ST_IDLE) && instValid;
    strobes.wrEn  = (state == ST_MOVE);
    strobes.slot  = slotIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slotIdx <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      unique case (state)
        ST_IDLE: if (instValid) state <= ST_CHECK;
        ST_CHECK: begin
          slotIdx <= '0;
          if (legal) state <= ST_MOVE;
          else begin
            illegal <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_MOVE: begin
          if (lastSlot) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            slotIdx <= slotIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmv_datapath.sv
module rmv_datapath
  import rmv_pkg::*;
#(
  parameter int REGS = NUM_REGS,
  parameter int WW   = WORD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrb_t           strobes,
  input  logic [INST_W-1:0]  instData,
  input  logic [ADDR_W-1:0]  instAddr,
  input  logic [REG_AW-1:0]  rdAddr,
  output logic [WW-1:0]      rdData,
  output logic [INST_W-1:0]  instHeld
);
  logic [WW-1:0]     regs [REGS];
  logic [ADDR_W-1:0] addrHeld;
  logic [7:0]        srcSpec, dstSpec, mode;
  logic [WW-1:0]     immWord, srcWord;

  always_comb begin
    srcSpec = instHeld[SRC_LSB + SPEC_W*int'(strobes.slot) +: SPEC_W];
    dstSpec = instHeld[DST_LSB + SPEC_W*int'(strobes.slot) +: SPEC_W];
    immWord = instHeld[IMM_LSB + WW*int'(strobes.slot) +: WW];
    mode    = instHeld[MODE_LSB +: 8];
    if (mode == MODE_IMM)            srcWord = immWord;
    else if (srcSpec == SPEC_PCLO)   srcWord = addrHeld[WW-1:0];
    else if (srcSpec == SPEC_PCHI)   srcWord = addrHeld[2*WW-1:WW];
    else                             srcWord = regs[srcSpec[REG_AW-1:0]];
  end

  assign rdData = regs[rdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instHeld <= '0;
      addrHeld <= '0;
    end else if (strobes.load) begin
      instHeld <= instData;
      addrHeld <= instAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REGS; i++) regs[i] <= '0;
    end else if (strobes.wrEn && (dstSpec < 8'(REGS))) begin
      regs[dstSpec[REG_AW-1:0]] <= srcWord;
    end
  end
endmodule

// File: rtl/regMoveUnit.sv
module regMoveUnit
  import rmv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic [INST_W-1:0] instData,
  input  logic [ADDR_W-1:0] instAddr,
  output logic              done,
  output logic              illegal,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  ctlStrb_t          strobes;
  logic [INST_W-1:0] instHeld;
  logic              legal;
  logic [SLOT_W:0]   moveCount;

  rmv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .legal(legal),
    .moveCount(moveCount), .instReady(instReady), .strobes(strobes),
    .done(done), .illegal(illegal)
  );

  rmv_legal #(.SLOTS(NUM_SLOTS), .REGS(NUM_REGS)) u_legal (
    .inst(instHeld), .legal(legal), .moveCount(moveCount)
  );

  rmv_datapath #(.REGS(NUM_REGS), .WW(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instData(instData),
    .instAddr(instAddr), .rdAddr(rdAddr), .rdData(rdData), .instHeld(instHeld)
  );
endmodule

// File: rtl/rmv_checker.sv
module rmv_checker (
  input logic clk,
  input logic rstN,
  input logic instValid,
  input logic instReady,
  input logic done,
  input logic illegal,
  input logic wrEn
);
  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(done && illegal));

  a_r9_illegal_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> !illegal);

  a_r9_illegal_no_write: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !wrEn);

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_done_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wrEn));

  a_r11_accept_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady) |=> !instReady);

  a_r11_busy_while_writing: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !instReady);
endmodule

bind regMoveUnit rmv_checker u_chk (
  .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
  .done(done), .illegal(illegal), .wrEn(strobes.wrEn)
);

// File: tb/regMoveUnit_test.sv
`timescale 1ns/1ps
module regMoveUnit_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         instValid = 1'b0;
  logic         instReady;
  logic [511:0] instData = '0;
  logic [63:0]  instAddr = '0;
  logic         done, illegal;
  logic [5:0]   rdAddr = '0;
  logic [31:0]  rdData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0]  ib [64];
  logic [31:0] mregs [64];

  regMoveUnit uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .instData(instData), .instAddr(instAddr), .done(done), .illegal(illegal),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [511:0] packInst();
    logic [511:0] w;
    for (int b = 0; b < 64; b++) w[8*b +: 8] = ib[b];
    return w;
  endfunction

  function automatic bit specOk(input logic [7:0] s);
    return (s < 64) || (s == 128) || (s == 129);
  endfunction

  function automatic bit refLegal();
    int n;
    n = ib[12];
    if (ib[0] != 8'hA7) return 0;
    if (n < 1 || n > 8) return 0;
    if (!(ib[13] == 8'h8 || ib[13] == 8'h9 || ib[13] == 8'hA)) return 0;
    if (ib[15] != 0) return 0;
    if (ib[14] > 1) return 0;
    for (int k = 0; k < 8; k++) begin
      if (k < n) begin
        if (!specOk(ib[16+k]) || !specOk(ib[24+k])) return 0;
      end else if (ib[16+k] != 0) return 0;
    end
    for (int k = 0; k < n; k++)
      for (int j = 0; j < n; j++) begin
        if (j != k && ib[24+k] == ib[24+j]) return 0;
        if (ib[24+k] == ib[16+j]) return 0;
      end
    return 1;
  endfunction

  task automatic clearInst(input logic [7:0] mode, input int n);
    for (int b = 0; b < 64; b++) ib[b] = 8'h00;
    ib[0] = 8'hA7; ib[12] = 8'(n); ib[13] = 8'h9; ib[14] = mode;
  endtask

  task automatic setSlot(input int k, input logic [7:0] s, input logic [7:0] d,
                         input logic [31:0] imm);
    ib[16+k] = s; ib[24+k] = d;
    for (int b = 0; b < 4; b++) ib[32+4*k+b] = imm[8*b +: 8];
  endtask

  task automatic compareRegs(input string tag);
    bit bad = 0;
    for (int r = 0; r < 64; r++) begin
      rdAddr = 6'(r);
      #1;
      if (!bad && rdData !== mregs[r]) begin
        bad = 1;
        $display("FAIL %s: reg %0d actual %h expected %h", tag, r, rdData, mregs[r]);
      end
    end
    checks++;
    if (bad) errors++;
  endtask

  task automatic runInst(input logic [63:0] pc, input string tag);
    bit expLegal, bad;
    int n, last;
    logic [31:0] v;
    expLegal = refLegal();
    n = ib[12];
    last = expLegal ? n + 3 : 3;
    bad = 0;
    @(negedge clk);
    instData = packInst(); instAddr = pc; instValid = 1'b1;
    @(posedge clk);
    for (int i = 1; i <= last; i++) begin
      bit eDone, eIll, eRdy;
      @(negedge clk);
      instValid = 1'b0;
      eDone = expLegal && (i == n + 2);
      eIll  = !expLegal && (i == 2);
      eRdy  = expLegal ? (i >= n + 2) : (i >= 2);
      if (!bad && (done !== eDone || illegal !== eIll || instReady !== eRdy)) begin
        bad = 1;
        $display("FAIL %s handshake cycle %0d: actual done=%b illegal=%b ready=%b expected done=%b illegal=%b ready=%b",
                 tag, i, done, illegal, instReady, eDone, eIll, eRdy);
      end
    end
    checks++;
    if (bad) errors++;
    if (expLegal) begin
      for (int k = 0; k < n; k++) begin
        if (ib[14] == 1) v = {ib[35+4*k], ib[34+4*k], ib[33+4*k], ib[32+4*k]};
        else if (ib[16+k] == 128) v = pc[31:0];
        else if (ib[16+k] == 129) v = pc[63:32];
        else v = mregs[ib[16+k]];
        if (ib[24+k] < 64) mregs[ib[24+k]] = v;
      end
    end
    compareRegs(tag);
  endtask

  initial begin
    for (int r = 0; r < 64; r++) mregs[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (instReady !== 1'b1 || done !== 1'b0 || illegal !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset outputs: actual ready=%b done=%b illegal=%b expected 1 0 0",
               instReady, done, illegal);
    end
    compareRegs("R12 reset registers");

    // R5 immediate mode, all eight slots, type 0x9
    clearInst(8'd1, 8);
    for (int k = 0; k < 8; k++) setSlot(k, 8'd128, 8'(k), 32'h1000_0001 * (k + 1));
    runInst(64'h0, "R5 R11 immediate eight slots");

    // R5 register mode, type 0x8
    clearInst(8'd0, 3); ib[13] = 8'h8;
    setSlot(0, 8'd0, 8'd10, 0); setSlot(1, 8'd1, 8'd11, 0); setSlot(2, 8'd2, 8'd12, 0);
    runInst(64'h0, "R5 register mode");

    // R3 type 0xA raw copy of a negative pattern
    clearInst(8'd1, 1); ib[13] = 8'hA;
    setSlot(0, 8'd128, 8'd40, 32'hBF80_0000);
    runInst(64'h0, "R3 fp32 raw word");
    clearInst(8'd1, 1); ib[13] = 8'h8;
    setSlot(0, 8'd129, 8'd41, 32'hFFFF_FF80);
    runInst(64'h0, "R3 int32 no extension");

    // R10 address capture and dropped writes
    clearInst(8'd0, 2);
    setSlot(0, 8'd128, 8'd20, 0); setSlot(1, 8'd129, 8'd21, 0);
    runInst(64'hDEAD_BEEF_1234_5678, "R10 address capture");
    clearInst(8'd1, 2);
    setSlot(0, 8'd5, 8'd128, 32'h5555_5555); setSlot(1, 8'd6, 8'd129, 32'h6666_6666);
    runInst(64'h0, "R10 dropped write");

    // Illegal cases, each also confirming R9
    clearInst(8'd1, 1); setSlot(0, 8'd128, 8'd30, 32'h1); ib[0] = 8'hA6;
    runInst(64'h0, "R1 R9 wrong opcode");
    clearInst(8'd1, 0);
    runInst(64'h0, "R2 R9 count zero");
    clearInst(8'd1, 9);
    runInst(64'h0, "R2 R9 count nine");
    clearInst(8'd1, 1); setSlot(0, 8'd128, 8'd30, 32'h1); ib[13] = 8'h7;
    runInst(64'h0, "R3 R9 bad type");
    clearInst(8'd1, 1); setSlot(0, 8'd128, 8'd30, 32'h1); ib[15] = 8'h1;
    runInst(64'h0, "R4 R9 reserved set");
    clearInst(8'd2, 1); setSlot(0, 8'd128, 8'd30, 32'h1);
    runInst(64'h0, "R5 R9 bad mode");
    clearInst(8'd0, 1); setSlot(0, 8'd64, 8'd30, 0);
    runInst(64'h0, "R6 R9 bad source specifier");
    clearInst(8'd0, 1); setSlot(0, 8'd1, 8'd130, 0);
    runInst(64'h0, "R6 R9 bad destination specifier");
    clearInst(8'd1, 1); setSlot(0, 8'd128, 8'd30, 32'h1); ib[16+5] = 8'd3;
    runInst(64'h0, "R7 R9 inactive source nonzero");
    clearInst(8'd1, 1); setSlot(0, 8'd128, 8'd30, 32'h7); ib[24+5] = 8'd77;
    runInst(64'h0, "R7 inactive destination ignored");
    clearInst(8'd1, 2); setSlot(0, 8'd128, 8'd30, 32'h1); setSlot(1, 8'd128, 8'd30, 32'h2);
    runInst(64'h0, "R8 R9 duplicate destination");
    clearInst(8'd0, 2); setSlot(0, 8'd1, 8'd30, 0); setSlot(1, 8'd30, 8'd31, 0);
    runInst(64'h0, "R8 R9 destination in source list");
    clearInst(8'd1, 1); setSlot(0, 8'd0, 8'd0, 32'h9);
    runInst(64'h0, "R8 R9 immediate mode alias");

    // Random legal instructions
    for (int t = 0; t < 40; t++) begin
      bit used [64];
      int n, d;
      logic [7:0] mode;
      n = 1 + int'($urandom % 8);
      mode = 8'($urandom % 2);
      clearInst(mode, n);
      ib[13] = 8'h8 + 8'($urandom % 3);
      for (int r = 0; r < 64; r++) used[r] = 0;
      for (int k = 0; k < n; k++) begin
        do d = int'($urandom % 64); while (used[d]);
        used[d] = 1;
        ib[24+k] = 8'(d);
      end
      for (int k = 0; k < n; k++) begin
        int s;
        if (mode == 1) s = 128;
        else begin
          s = int'($urandom % 66);
          if (s >= 64) s = s + 64;
          else while (used[s]) s = (s + 1) % 64;
        end
        setSlot(k, 8'(s), ib[24+k], $urandom);
      end
      runInst({$urandom, $urandom}, "R5 R11 random legal");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule